// File: doc/BRIEF.md
# SCSI Controller Register and Command Unit

This block is the host-facing register bank and command decoder of a parallel-bus SCSI initiator controller. Software reaches it through a byte-wide write port and a byte-wide read port, both addressed by a small register offset. The offsets cover a transfer-count pair, a byte FIFO window, a command register, status, interrupt, sequence-step, flags and configuration registers, and a read-only chip-identification byte. Every byte written to the command register is decoded into an action. These actions are flushing the FIFO, resetting the chip, resetting the SCSI bus, the initiator command-complete sequence, accepting a message, raising ATN, starting a selection, and enabling selection. Each action updates the interrupt, status, sequence-step and flags state, and a single level interrupt output follows the interrupt-pending bit of the status register.

Selection itself is not run here. When the addressed target is marked present, the block hands the request to a separate transfer engine through a one-cycle start strobe, together with the target number and a stop-after-command qualifier. The engine reports its finish through a done pulse. Reading the interrupt register has side effects: the byte read is returned, then the interrupt register, the terminal-count status and the interrupt output are cleared and the sequence step is loaded with the command-done code.

Top module: `scsi_regcmd`

## Requirements
- R1: After a hard reset or a chip-reset command (0x02), the counts, status, interrupt, sequence step, flags and FIFO all read zero, the ATN output is low, the chip-ID byte at offset 9 reads 0x04 and configuration register 1 at offset 8 reads 0x07.
- R2: The command decoder uses only bits 6:0 of the command byte at offset 3, with bit 7 ignored. An unrecognised code ORs 0x40 into the interrupt register and changes neither the interrupt output nor the status.
- R3: The interrupt output always equals status bit 7. A read of the interrupt register at offset 5 returns its value, and afterwards the interrupt register is 0, status bit 4 (terminal count) is 0, the sequence step at offset 6 is 4 and the interrupt output is low.
- R4: Bus reset (0x03) writes 0x80 to the interrupt register. It raises the interrupt only when bit 6 of configuration register 1 is clear.
- R5: Flush (0x01) empties the FIFO, sets the interrupt register to 0x08 (function complete), zeroes the sequence step and flags, clears status bit 6, and does not raise the interrupt.
- R6: Message accepted (0x12) sets the interrupt register to 0x20 (disconnect), zeroes the sequence step, empties the FIFO so the flags read 0, and raises the interrupt. Enable selection (0x44) clears the interrupt register and leaves the interrupt output unchanged.
- R7: The initiator command-complete sequence (0x11) sets the interrupt register to 0x08, sets status bits 2:0 to 7 (message-in phase) and raises the interrupt.
- R8: Set ATN (0x1A) drives the ATN output high until the next hard or chip reset, without touching the interrupt register.
- R9: The target number is bits 2:0 of the byte written to offset 4. For select with ATN (0x42) or select with ATN and stop (0x43) to a present target, the start strobe is high for exactly the cycle after the command write, with that target number and the stop qualifier set only for 0x43. For an absent target there is no strobe: the interrupt register becomes 0x20, the sequence step 0, the status reads 0x80 and the interrupt is raised.
- R10: A write to offset 2 pushes a byte and a read of offset 2 pops the oldest one (an empty read returns 0). The flags register at offset 7 reports the FIFO count in bits 4:0. A FIFO write clears status bit 4.
- R11: A FIFO write while the FIFO holds one byte less than its depth is dropped, leaves the count and contents unchanged, and sets status bit 6 (overrun error).
- R12: A transfer-engine done pulse sets status bit 4, ORs 0x10 (bus service) into the interrupt register and raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write offset |
| wr_data | input | 8 | Register write byte |
| rd_en | input | 1 | Register read strobe (enables read side effects) |
| rd_addr | input | 4 | Register read offset |
| rd_data | output | 8 | Register read byte for rd_addr, valid in the same cycle |
| eng_done | input | 1 | Completion pulse from the transfer engine |
| target_present | input | 8 | One bit per target number, set when that target exists |
| irq | output | 1 | Level interrupt request |
| atn | output | 1 | ATN request toward the bus logic |
| sel_start | output | 1 | One-cycle selection start strobe to the transfer engine |
| sel_target | output | 3 | Target number for the selection |
| sel_stop | output | 1 | Selection stops after the command phase |

## Verification
The hardest state to reach is the FIFO overrun. It requires filling the FIFO to exactly one byte below its depth, so the stimulus writes depth minus one bytes, confirms the count through the flags register, and then writes one more. The check then reads back the status error bit, the unchanged count and the oldest byte, before a flush clears the error. The masked bus-reset case also needs a prepared state: the stimulus first writes configuration register 1 with bit 6 set, then issues bus reset and checks that the interrupt register holds 0x80 while the interrupt output stays low.

// File: rtl/scsi_rc_pkg.sv
package scsi_rc_pkg;

    localparam int ADDR_W = 4;
    localparam int TID_W  = 3;
    localparam int NTGT   = 1 << TID_W;

    typedef logic [ADDR_W-1:0] raddr_t;

    // register offsets
    localparam raddr_t A_TCLO    = 4'h0;
    localparam raddr_t A_TCMID   = 4'h1;
    localparam raddr_t A_FIFO    = 4'h2;
    localparam raddr_t A_CMD     = 4'h3;
    localparam raddr_t A_STAT_ID = 4'h4;  // read: status, write: target id
    localparam raddr_t A_INTR    = 4'h5;
    localparam raddr_t A_SEQ     = 4'h6;
    localparam raddr_t A_FLAGS   = 4'h7;
    localparam raddr_t A_CFG1    = 4'h8;
    localparam raddr_t A_TCHI    = 4'h9;

    // interrupt register codes
    localparam logic [7:0] INT_FC     = 8'h08;
    localparam logic [7:0] INT_BS     = 8'h10;
    localparam logic [7:0] INT_DC     = 8'h20;
    localparam logic [7:0] INT_BAD    = 8'h40;
    localparam logic [7:0] INT_BUSRST = 8'h80;

    localparam logic [7:0] CHIP_ID    = 8'h04;
    localparam logic [7:0] CFG1_DEF   = 8'h07;
    localparam int         CFG1_MASKB = 6;
    localparam logic [2:0] SEQ_DONE   = 3'd4;
    localparam logic [2:0] PH_MSGIN   = 3'b111;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_FLUSH,
        OP_CHIPRST,
        OP_BUSRST,
        OP_ICCS,
        OP_MSGACC,
        OP_SETATN,
        OP_SEL,
        OP_SELSTOP,
        OP_ENSEL,
        OP_BAD
    } cmd_op_e;

    typedef struct packed {
        logic       intp;   // bit 7
        logic       gerr;   // bit 6
        logic       rsv5;
        logic       tc;     // bit 4
        logic       rsv3;
        logic [2:0] phase;  // bits 2:0
    } stat_t;

    typedef struct packed {
        logic [7:0]       tc_lo;
        logic [7:0]       tc_mid;
        logic [7:0]       tc_hi;
        logic [7:0]       cfg1;
        logic [7:0]       cmd;
        logic [7:0]       intr;
        stat_t            stat;
        logic [2:0]       seq;
        logic [TID_W-1:0] busid;
        logic             atn;
    } regs_t;

    function automatic regs_t regs_after_reset();
        regs_t r;
        r       = '0;
        r.tc_hi = CHIP_ID;
        r.cfg1  = CFG1_DEF;
        return r;
    endfunction

    function automatic cmd_op_e decode_cmd(input logic [6:0] code);
        case (code)
            7'h00:   return OP_NOP;
            7'h01:   return OP_FLUSH;
            7'h02:   return OP_CHIPRST;
            7'h03:   return OP_BUSRST;
            7'h11:   return OP_ICCS;
            7'h12:   return OP_MSGACC;
            7'h1A:   return OP_SETATN;
            7'h42:   return OP_SEL;
            7'h43:   return OP_SELSTOP;
            7'h44:   return OP_ENSEL;
            default: return OP_BAD;
        endcase
    endfunction

endpackage

// File: rtl/scsi_rc_fifo.sv
module scsi_rc_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          overrun
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH - 1);
    localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    assign push_ok = push && (count != FULL_LVL);
    assign overrun = push && (count == FULL_LVL);
    assign pop_ok  = pop && (count != '0);
    assign dout    = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IX) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) begin
                mem[wptr] <= din;
                wptr      <= bump(wptr);
            end
            if (pop_ok) rptr <= bump(rptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    assert_count_bound_R11: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_LVL);

    assert_overrun_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (overrun && !pop && !flush) |=> $stable(count));

endmodule

// File: rtl/scsi_rc_decode.sv
module scsi_rc_decode
    import scsi_rc_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_op_e    op,
    output logic       is_sel,
    output logic       sel_stop
);
    logic [6:0] code;
    assign code     = cmd_byte[6:0];   // bit 7 is a transfer-mode flag, not decoded here
    assign op       = decode_cmd(code);
    assign is_sel   = (op == OP_SEL) || (op == OP_SELSTOP);
    assign sel_stop = (op == OP_SELSTOP);
endmodule

// File: rtl/scsi_regcmd.sv
module scsi_regcmd
    import scsi_rc_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    input  logic [3:0]       rd_addr,
    output logic [7:0]       rd_data,
    input  logic             eng_done,
    input  logic [7:0]       target_present,
    output logic             irq,
    output logic             atn,
    output logic             sel_start,
    output logic [2:0]       sel_target,
    output logic             sel_stop
);
    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    regs_t            cur, nxt;
    logic             sel_q, sel_n, stop_q, stop_n;
    logic [TID_W-1:0] tgt_q, tgt_n;

    logic             wr_cmd, fifo_push, fifo_pop, rd_intr;
    logic             soft_rst, flush_req;
    cmd_op_e          op;
    logic             op_is_sel, op_stop;
    logic [7:0]       fifo_head;
    logic [CNT_W-1:0] fifo_cnt;
    logic             fifo_ovr;

    assign wr_cmd    = wr_en && (wr_addr == A_CMD);
    assign fifo_push = wr_en && (wr_addr == A_FIFO);
    assign fifo_pop  = rd_en && (rd_addr == A_FIFO);
    assign rd_intr   = rd_en && (rd_addr == A_INTR);

    scsi_rc_decode u_dec (
        .cmd_byte (wr_data),
        .op       (op),
        .is_sel   (op_is_sel),
        .sel_stop (op_stop)
    );

    scsi_rc_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush_req),
        .push    (fifo_push),
        .din     (wr_data),
        .pop     (fifo_pop),
        .dout    (fifo_head),
        .count   (fifo_cnt),
        .overrun (fifo_ovr)
    );

    // next-state: read side effects, engine report, then write effects
    always_comb begin
        nxt       = cur;
        sel_n     = 1'b0;
        stop_n    = 1'b0;
        tgt_n     = cur.busid;
        soft_rst  = 1'b0;
        flush_req = 1'b0;

        if (rd_intr) begin
            nxt.intr      = '0;
            nxt.stat.tc   = 1'b0;
            nxt.stat.intp = 1'b0;
            nxt.seq       = SEQ_DONE;
        end

        if (eng_done) begin
            nxt.stat.tc   = 1'b1;
            nxt.intr      = nxt.intr | INT_BS;
            nxt.stat.intp = 1'b1;
        end

        if (fifo_ovr) nxt.stat.gerr = 1'b1;

        if (wr_en) begin
            case (wr_addr)
                A_TCLO:    nxt.tc_lo  = wr_data;
                A_TCMID:   nxt.tc_mid = wr_data;
                A_FIFO:    nxt.stat.tc = 1'b0;
                A_STAT_ID: nxt.busid  = wr_data[TID_W-1:0];
                A_CFG1:    nxt.cfg1   = wr_data;
                A_CMD: begin
                    nxt.cmd = wr_data;
                    case (op)
                        OP_FLUSH: begin
                            flush_req     = 1'b1;
                            nxt.intr      = INT_FC;
                            nxt.seq       = '0;
                            nxt.stat.gerr = 1'b0;
                        end
                        OP_CHIPRST: begin
                            soft_rst  = 1'b1;
                            flush_req = 1'b1;
                        end
                        OP_BUSRST: begin
                            nxt.intr = INT_BUSRST;
                            if (!cur.cfg1[CFG1_MASKB]) nxt.stat.intp = 1'b1;
                        end
                        OP_ICCS: begin
                            nxt.intr       = INT_FC;
                            nxt.stat.phase = PH_MSGIN;
                            nxt.stat.intp  = 1'b1;
                        end
                        OP_MSGACC: begin
                            flush_req     = 1'b1;
                            nxt.intr      = INT_DC;
                            nxt.seq       = '0;
                            nxt.stat.intp = 1'b1;
                        end
                        OP_SETATN: nxt.atn = 1'b1;
                        OP_SEL, OP_SELSTOP: begin
                            if (target_present[cur.busid]) begin
                                sel_n  = op_is_sel;
                                stop_n = op_stop;
                            end else begin
                                nxt.stat      = '0;
                                nxt.stat.intp = 1'b1;
                                nxt.intr      = INT_DC;
                                nxt.seq       = '0;
                            end
                        end
                        OP_ENSEL: nxt.intr = '0;
                        OP_BAD:   nxt.intr = nxt.intr | INT_BAD;
                        default:  ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cur    <= regs_after_reset();
            sel_q  <= 1'b0;
            stop_q <= 1'b0;
            tgt_q  <= '0;
        end else begin
            cur    <= nxt;
            sel_q  <= sel_n;
            stop_q <= stop_n;
            tgt_q  <= tgt_n;
        end
    end

    // read mux, combinational on the current state
    always_comb begin
        case (rd_addr)
            A_TCLO:    rd_data = cur.tc_lo;
            A_TCMID:   rd_data = cur.tc_mid;
            A_TCHI:    rd_data = cur.tc_hi;
            A_FIFO:    rd_data = (fifo_cnt != '0) ? fifo_head : 8'h00;
            A_CMD:     rd_data = cur.cmd;
            A_STAT_ID: rd_data = cur.stat;
            A_INTR:    rd_data = cur.intr;
            A_SEQ:     rd_data = {5'b0, cur.seq};
            A_FLAGS:   rd_data = 8'(fifo_cnt);
            A_CFG1:    rd_data = cur.cfg1;
            default:   rd_data = 8'h00;
        endcase
    end

    assign irq        = cur.stat.intp;
    assign atn        = cur.atn;
    assign sel_start  = sel_q;
    assign sel_stop   = stop_q;
    assign sel_target = tgt_q;

    assert_intr_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_intr && !eng_done && !wr_cmd) |=> (!irq && cur.intr == 8'h00));

    assert_busrst_masked_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && op == OP_BUSRST && cur.cfg1[CFG1_MASKB] && !eng_done && !irq)
        |=> !irq);

    assert_sel_from_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        sel_start |-> $past(wr_cmd));

    assert_irq_cause_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(eng_done || wr_cmd));

    assert_bad_keeps_irq_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && op == OP_BAD && !eng_done && !rd_intr) |=> $stable(irq));

endmodule

// File: tb/scsi_regcmd_bench.sv
`timescale 1ns/1ps
module scsi_regcmd_bench;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en, eng_done;
    logic [3:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data, target_present;
    logic       irq, atn, sel_start, sel_stop;
    logic [2:0] sel_target;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    scsi_regcmd #(.FIFO_DEPTH(DEPTH)) u_scsi_regcmd (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .eng_done(eng_done),
        .target_present(target_present), .irq(irq), .atn(atn),
        .sel_start(sel_start), .sel_target(sel_target), .sel_stop(sel_stop)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, $sformatf("reg%0h", a), v, exp);
    endtask

    task automatic pulse_done();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1", 4'h0, 8'h00); rd_chk("R1", 4'h1, 8'h00);
        rd_chk("R1", 4'h4, 8'h00); rd_chk("R1", 4'h5, 8'h00);
        rd_chk("R1", 4'h7, 8'h00); rd_chk("R1", 4'h9, 8'h04);
        rd_chk("R1", 4'h8, 8'h07);
        chk("R1", "irq", {7'b0, irq}, 8'h00);
        chk("R1", "atn", {7'b0, atn}, 8'h00);
        // sequence step after reset read of interrupt register becomes 4
        rd_chk("R3", 4'h6, 8'h04);
    endtask

    task automatic t_fifo();
        wr(4'h2, 8'hA1); wr(4'h2, 8'hB2); wr(4'h2, 8'hC3);
        rd_chk("R10", 4'h7, 8'h03);
        rd_chk("R10", 4'h2, 8'hA1);
        rd_chk("R10", 4'h2, 8'hB2);
        rd_chk("R10", 4'h2, 8'hC3);
        rd_chk("R10", 4'h7, 8'h00);
        rd_chk("R10", 4'h2, 8'h00);
    endtask

    task automatic t_overrun_flush();
        for (int i = 0; i < DEPTH - 1; i++) wr(4'h2, 8'(8'h10 + i));
        rd_chk("R11", 4'h7, 8'(DEPTH - 1));
        rd_chk("R11", 4'h4, 8'h00);
        wr(4'h2, 8'hEE);
        rd_chk("R11", 4'h7, 8'(DEPTH - 1));
        rd_chk("R11", 4'h4, 8'h40);
        rd_chk("R11", 4'h2, 8'h10);
        wr(4'h3, 8'h01);
        chk("R5", "irq after flush", {7'b0, irq}, 8'h00);
        rd_chk("R5", 4'h7, 8'h00);
        rd_chk("R5", 4'h4, 8'h00);
        rd_chk("R5", 4'h6, 8'h00);
        rd_chk("R5", 4'h5, 8'h08);
    endtask

    task automatic t_busrst();
        wr(4'h3, 8'h03);
        chk("R4", "irq unmasked", {7'b0, irq}, 8'h01);
        rd_chk("R4", 4'h4, 8'h80);
        rd_chk("R4", 4'h5, 8'h80);
        chk("R3", "irq after intr read", {7'b0, irq}, 8'h00);
        rd_chk("R3", 4'h5, 8'h00);
        rd_chk("R3", 4'h6, 8'h04);
        wr(4'h8, 8'h47);
        wr(4'h3, 8'h03);
        chk("R4", "irq masked", {7'b0, irq}, 8'h00);
        rd_chk("R4", 4'h5, 8'h80);
        wr(4'h8, 8'h07);
    endtask

    task automatic t_engdone();
        pulse_done();
        chk("R12", "irq", {7'b0, irq}, 8'h01);
        rd_chk("R12", 4'h4, 8'h90);
        rd_chk("R12", 4'h5, 8'h10);
        rd_chk("R3", 4'h4, 8'h00);
        rd_chk("R3", 4'h6, 8'h04);
        pulse_done();
        wr(4'h2, 8'h55);
        rd_chk("R10", 4'h4, 8'h80);
        rd_chk("R12", 4'h5, 8'h10);
        wr(4'h3, 8'h01);
        rd_chk("R5", 4'h5, 8'h08);
    endtask

    task automatic t_msgacc_ensel();
        wr(4'h2, 8'h01); wr(4'h2, 8'h02);
        rd_chk("R6", 4'h6, 8'h04);
        wr(4'h3, 8'h12);
        chk("R6", "irq", {7'b0, irq}, 8'h01);
        rd_chk("R6", 4'h7, 8'h00);
        rd_chk("R6", 4'h6, 8'h00);
        wr(4'h3, 8'h44);
        chk("R6", "irq after ensel", {7'b0, irq}, 8'h01);
        rd_chk("R6", 4'h5, 8'h00);
        chk("R3", "irq cleared", {7'b0, irq}, 8'h00);
        wr(4'h3, 8'h12);
        rd_chk("R6", 4'h5, 8'h20);
    endtask

    task automatic t_iccs();
        wr(4'h3, 8'h11);
        chk("R7", "irq", {7'b0, irq}, 8'h01);
        rd_chk("R7", 4'h4, 8'h87);
        rd_chk("R7", 4'h5, 8'h08);
        rd_chk("R3", 4'h4, 8'h07);
    endtask

    task automatic t_atn();
        wr(4'h3, 8'h1A);
        chk("R8", "atn", {7'b0, atn}, 8'h01);
        rd_chk("R8", 4'h5, 8'h00);
        chk("R8", "irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_select();
        target_present = 8'b0010_0000;
        wr(4'h4, 8'h0D);
        wr(4'h3, 8'h43);
        chk("R9", "start", {7'b0, sel_start}, 8'h01);
        chk("R9", "target", {5'b0, sel_target}, 8'h05);
        chk("R9", "stop", {7'b0, sel_stop}, 8'h01);
        @(negedge clk);
        chk("R9", "start width", {7'b0, sel_start}, 8'h00);
        chk("R9", "no irq", {7'b0, irq}, 8'h00);
        wr(4'h3, 8'h42);
        chk("R9", "start 42", {7'b0, sel_start}, 8'h01);
        chk("R9", "stop 42", {7'b0, sel_stop}, 8'h00);
        wr(4'h4, 8'h02);
        wr(4'h3, 8'h42);
        chk("R9", "absent no start", {7'b0, sel_start}, 8'h00);
        chk("R9", "absent irq", {7'b0, irq}, 8'h01);
        rd_chk("R9", 4'h4, 8'h80);
        rd_chk("R9", 4'h6, 8'h00);
        rd_chk("R9", 4'h5, 8'h20);
    endtask

    task automatic t_illegal_bit7();
        wr(4'h3, 8'h55);
        chk("R2", "irq unchanged", {7'b0, irq}, 8'h00);
        rd_chk("R2", 4'h4, 8'h00);
        rd_chk("R2", 4'h5, 8'h40);
        wr(4'h3, 8'h91);
        chk("R2", "bit7 ignored irq", {7'b0, irq}, 8'h01);
        rd_chk("R2", 4'h5, 8'h08);
    endtask

    task automatic t_chiprst();
        wr(4'h0, 8'h33); wr(4'h8, 8'h40); wr(4'h2, 8'h77); wr(4'h3, 8'h1A);
        wr(4'h3, 8'h82);
        rd_chk("R1", 4'h0, 8'h00);
        rd_chk("R1", 4'h8, 8'h07);
        rd_chk("R1", 4'h7, 8'h00);
        rd_chk("R1", 4'h9, 8'h04);
        rd_chk("R1", 4'h4, 8'h00);
        chk("R1", "atn after chip reset", {7'b0, atn}, 8'h00);
        chk("R1", "irq after chip reset", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; eng_done = 1'b0;
        wr_addr = '0; rd_addr = '0; wr_data = '0; target_present = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fifo();
        t_overrun_flush();
        t_busrst();
        t_engdone();
        t_msgacc_ensel();
        t_iccs();
        t_atn();
        t_select();
        t_illegal_bit7();
        t_chiprst();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule